// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is a full-duplex serial port that moves fixed eight-bit characters together with a serial clock. Software-side logic hands transmit bytes in over a ready/valid handshake and collects received bytes over a second ready/valid handshake. Each direction keeps one holding register in front of its shift register. While one character is on the wire, the next can wait in the holding register, so characters follow each other without idle bit times.

The serial clock comes from one of two sources. In internal mode a one-cycle rate enable toggles a clock that the block drives onto its clock pin. The clock idles high and runs only while there are characters to send. In external mode the block stops driving the pin. It passes the incoming clock through a synchroniser, and its edges then drive the shifting. Data leaves least significant bit first, changes after a falling clock edge and is sampled on the rising edge. The only receive error is overrun, which is reported with a sticky flag.

Top module: `csync_serial_port`

## Requirements
- R1: After reset, txReady=1, rxValid=0, txEnd=1, overrun=0, sckOut=1 and txd=1.
- R2: A character is eight bits, bit 0 first. The transmit line takes each new bit after a falling serial-clock edge, and the receiver captures rxd on each rising edge.
- R3: With extClkSel=0, sckOe=1, sckOut idles high and each character produces exactly eight low-then-high clock pulses. With extClkSel=1, sckOe=0.
- R4: In internal mode, a byte written into the holding register before the current character's eighth rising edge is sent directly after it, with no idle clock period and no txEnd in between.
- R5: In internal mode, if the holding register is empty at a character's eighth rising edge, the clock stops high and txEnd becomes 1. txEnd returns to 0 when the next character starts.
- R6: A completed received byte is shown on rxData with rxValid=1 and stays unchanged until it is taken with rxReady=1.
- R7: If a character completes while an untaken byte is held, overrun becomes 1 and the held byte is kept. overrun stays 1 until ovrClr is pulsed.
- R8: In external mode the synchronised edges of sckIn shift the data. If the holding register is empty when a character begins, that character transmits all ones.
- R9: txReady is 0 in the cycle after a byte is accepted, and stays 0 until that byte moves into the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extClkSel | input | 1 | 1 selects the external clock, 0 the internal one |
| bitTick | input | 1 | Internal rate enable; each pulse toggles the serial clock |
| sckIn | input | 1 | External serial clock |
| sckOut | output | 1 | Driven serial clock (internal mode) |
| sckOe | output | 1 | Drive enable for the clock pin |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | Holding register is free |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | rxData holds an untaken byte |
| rxReady | input | 1 | Consumer takes rxData |
| txEnd | output | 1 | Internal clock stopped after the last character |
| overrun | output | 1 | Sticky overrun flag |
| ovrClr | input | 1 | Clears overrun |

## Verification
The assertions check on every cycle that an untaken received byte neither changes nor disappears, that overrun is sticky, that an accepted write closes the holding register, and that in internal mode the idle clock is high and txd changes only at a falling clock edge. The bench scenarios show the rest. An internal-mode loopback sweep over all 256 byte values checks bit order, the pulse count and gap-free streaming. Further scenarios drive the external clock by hand, provoke an overrun, and check the fill pattern sent when the holding register is empty.

// File: rtl/csync_pkg.sv
package csync_pkg;
  localparam int CHAR_BITS = 8;
  localparam int IDX_W = $clog2(CHAR_BITS);

  // strobes from control to datapath
  typedef struct packed {
    logic             shiftOut;   // falling serial edge
    logic             sampleIn;   // rising serial edge
    logic             startChar;  // falling edge that opens a character
    logic             charDone;   // rising edge that closes a character
    logic [IDX_W-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/csync_ctrl.sv
module csync_ctrl
  import csync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    extClkSel,
  input  logic    bitTick,
  input  logic    sckIn,
  input  logic    holdFull,
  output logic    sckOut,
  output logic    txEnd,
  output strobe_t strb
);
  localparam int CHAIN_W = SYNC_STAGES + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_BITS - 1);

  logic [CHAIN_W-1:0] syncChain;
  logic               extRise, extFall;
  logic               sckReg, running;
  logic               intRise, intFall;
  logic               fallEv, riseEv;
  logic [IDX_W-1:0]   bitCnt;

  // synchroniser plus one extra stage for edge detection
  genvar g;
  generate
    for (g = 0; g < CHAIN_W; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b1;
        else if (g == 0) syncChain[g] <= sckIn;
        else syncChain[g] <= syncChain[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign extRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];
  assign extFall = ~syncChain[SYNC_STAGES-1] & syncChain[SYNC_STAGES];

  assign intFall = running & bitTick & sckReg;
  assign intRise = running & bitTick & ~sckReg;

  assign fallEv = extClkSel ? extFall : intFall;
  assign riseEv = extClkSel ? extRise : intRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckReg  <= 1'b1;
      running <= 1'b0;
      txEnd   <= 1'b1;
    end else if (extClkSel) begin
      sckReg  <= 1'b1;
      running <= 1'b0;
    end else if (!running) begin
      if (holdFull) begin
        running <= 1'b1;
        txEnd   <= 1'b0;
      end
    end else if (bitTick) begin
      sckReg <= ~sckReg;
      if (!sckReg && bitCnt == LAST_IDX && !holdFull) begin
        running <= 1'b0;
        txEnd   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (riseEv) bitCnt <= bitCnt + 1'b1;
  end

  assign sckOut         = sckReg;
  assign strb.shiftOut  = fallEv;
  assign strb.sampleIn  = riseEv;
  assign strb.startChar = fallEv && (bitCnt == '0);
  assign strb.charDone  = riseEv && (bitCnt == LAST_IDX);
  assign strb.bitIdx    = bitCnt;
endmodule

// File: rtl/csync_dpath.sv
module csync_dpath
  import csync_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 rxd,
  input  logic [CHAR_BITS-1:0] txData,
  input  logic                 txValid,
  input  logic                 rxReady,
  input  logic                 ovrClr,
  output logic                 holdFull,
  output logic                 txd,
  output logic [CHAR_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 overrun
);
  logic [CHAR_BITS-1:0] txHold, txShift, rxShift, rxNext;
  logic [CHAR_BITS-1:0] nextChar;
  logic                 writeAcc;

  assign writeAcc = txValid && !holdFull;
  assign nextChar = holdFull ? txHold : '1;

  // transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold   <= '0;
      holdFull <= 1'b0;
      txShift  <= '1;
      txd      <= 1'b1;
    end else begin
      if (writeAcc) begin
        txHold   <= txData;
        holdFull <= 1'b1;
      end else if (strb.startChar) begin
        holdFull <= 1'b0;
      end
      if (strb.startChar) begin
        txShift <= nextChar;
        txd     <= nextChar[0];
      end else if (strb.shiftOut) begin
        txd <= txShift[strb.bitIdx];
      end
    end
  end

  // receive side: assemble the completed byte including the last bit
  always_comb begin
    rxNext = rxShift;
    rxNext[strb.bitIdx] = rxd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strb.sampleIn) rxShift <= rxNext;
      if (strb.charDone && rxValid && !rxReady) begin
        overrun <= 1'b1;
      end else begin
        if (ovrClr) overrun <= 1'b0;
        if (strb.charDone) begin
          rxData  <= rxNext;
          rxValid <= 1'b1;
        end else if (rxReady) begin
          rxValid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/csync_serial_port.sv
module csync_serial_port
  import csync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClkSel,
  input  logic       bitTick,
  input  logic       sckIn,
  output logic       sckOut,
  output logic       sckOe,
  output logic       txd,
  input  logic       rxd,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic [7:0] rxData,
  output logic       rxValid,
  input  logic       rxReady,
  output logic       txEnd,
  output logic       overrun,
  input  logic       ovrClr
);
  strobe_t strb;
  logic    holdFull;

  csync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .extClkSel(extClkSel), .bitTick(bitTick),
    .sckIn(sckIn), .holdFull(holdFull), .sckOut(sckOut), .txEnd(txEnd),
    .strb(strb)
  );

  csync_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxd(rxd), .txData(txData),
    .txValid(txValid), .rxReady(rxReady), .ovrClr(ovrClr),
    .holdFull(holdFull), .txd(txd), .rxData(rxData), .rxValid(rxValid),
    .overrun(overrun)
  );

  assign sckOe   = ~extClkSel;
  assign txReady = ~holdFull;
endmodule

// File: rtl/csync_checker.sv
module csync_checker (
  input logic       clk,
  input logic       rstN,
  input logic       extClkSel,
  input logic       sckOut,
  input logic       txd,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       rxReady,
  input logic       txEnd,
  input logic       overrun,
  input logic       ovrClr
);
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!extClkSel && txEnd) |-> sckOut);

  p_txd_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!extClkSel && $stable(extClkSel) && !$stable(txd)) |-> $fell(sckOut));

  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> rxValid);

  p_keep_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> $stable(rxData));

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovrClr) |=> overrun);

  p_hold_closed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);
endmodule

bind csync_serial_port csync_checker uChk (
  .clk(clk), .rstN(rstN), .extClkSel(extClkSel), .sckOut(sckOut),
  .txd(txd), .txValid(txValid), .txReady(txReady), .rxData(rxData),
  .rxValid(rxValid), .rxReady(rxReady), .txEnd(txEnd),
  .overrun(overrun), .ovrClr(ovrClr)
);

// File: tb/sim_csync_serial_port.sv
module sim_csync_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 256;

  logic clk = 1'b0, rstN = 1'b0;
  logic extClkSel = 1'b0, bitTick = 1'b0, sckIn = 1'b1, rxdDrv = 1'b1, loopOn = 1'b1;
  logic sckOut, sckOe, txd, rxd, txReady, rxValid, txEnd, overrun;
  logic [7:0] txData = '0, rxData;
  logic txValid = 1'b0, rxReady = 1'b0, ovrClr = 1'b0;

  int total = 0, bad = 0, cycles = 0;
  int sckRises = 0, endRises = 0, rxCount = 0, rxMis = 0;
  logic monOn = 1'b0, prevSck = 1'b1, prevEnd = 1'b1;

  assign rxd = loopOn ? txd : rxdDrv;

  csync_serial_port u0 (
    .clk(clk), .rstN(rstN), .extClkSel(extClkSel), .bitTick(bitTick),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .txd(txd), .rxd(rxd),
    .txData(txData), .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .rxReady(rxReady), .txEnd(txEnd), .overrun(overrun),
    .ovrClr(ovrClr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    bitTick = ~bitTick;
  end

  // monitors sampled away from the active edge
  always @(negedge clk) begin
    cycles <= cycles + 1;
    prevSck <= sckOut;
    prevEnd <= txEnd;
    if (monOn) begin
      if (sckOut && !prevSck) sckRises <= sckRises + 1;
      if (txEnd && !prevEnd) endRises <= endRises + 1;
      if (rxValid) begin
        if (rxData != rxCount[7:0]) rxMis <= rxMis + 1;
        rxCount <= rxCount + 1;
      end
    end
    if (cycles > 150000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = b; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!txEnd) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // one external clock period: fall, hold, sample txd, rise, hold
  task automatic extBit(input logic dIn, output logic dOut);
    @(negedge clk);
    sckIn = 1'b0; rxdDrv = dIn;
    repeat (8) @(negedge clk);
    dOut = txd;
    sckIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic extChar(input logic [7:0] inB, output logic [7:0] outB);
    for (int i = 0; i < 8; i++) begin
      logic b;
      extBit(inB[i], b);
      outB[i] = b;
    end
  endtask

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 txReady", txReady, 1);
    check("R1 rxValid", rxValid, 0);
    check("R1 txEnd", txEnd, 1);
    check("R1 overrun", overrun, 0);
    check("R1 sckOut", sckOut, 1);
    check("R1 txd", txd, 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 sckOe internal", sckOe, 1);
    check("R3 idle clock high", sckOut, 1);

    // R2 R4: loopback sweep of every byte value, back to back
    rxReady = 1'b1; monOn = 1'b1;
    for (int v = 0; v < NBYTES; v++) sendByte(v[7:0]);
    waitIdle();
    monOn = 1'b0;
    check("R2 bytes received", rxCount, NBYTES);
    check("R2 loopback mismatches", rxMis, 0);
    check("R3 pulses per sweep", sckRises, 8 * NBYTES);
    check("R4 txEnd rises in sweep", endRises, 1);
    check("R5 txEnd after last", txEnd, 1);
    check("R3 clock stopped high", sckOut, 1);

    // R5: single character, txEnd low while running
    sendByte(8'h5A);
    repeat (4) @(negedge clk);
    check("R5 txEnd cleared on start", txEnd, 0);
    waitIdle();
    check("R5 txEnd set at stop", txEnd, 1);

    // R6 R7: overrun with two characters and no read
    rxReady = 1'b0;
    sendByte(8'h3C);
    sendByte(8'hA5);
    waitIdle();
    check("R6 rxValid held", rxValid, 1);
    check("R7 held byte kept", rxData, 8'h3C);
    check("R7 overrun set", overrun, 1);
    repeat (5) @(negedge clk);
    check("R7 overrun sticky", overrun, 1);
    ovrClr = 1'b1; @(negedge clk); ovrClr = 1'b0;
    check("R7 overrun cleared", overrun, 0);
    rxReady = 1'b1; @(negedge clk); rxReady = 1'b0;
    check("R6 taken", rxValid, 0);

    // R8: external clock mode
    extClkSel = 1'b1; loopOn = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 sckOe external", sckOe, 0);
    sendByte(8'h96);
    repeat (20) @(negedge clk);
    check("R9 hold stays full without clock", txReady, 0);
    extChar(8'hC3, got);
    check("R8 ext tx bits", got, 8'h96);
    repeat (4) @(negedge clk);
    check("R8 ext rx valid", rxValid, 1);
    check("R8 ext rx byte", rxData, 8'hC3);
    check("R9 hold freed", txReady, 1);
    rxReady = 1'b1; @(negedge clk); rxReady = 1'b0;
    extChar(8'h01, got);
    check("R8 empty hold sends ones", got, 8'hFF);
    repeat (4) @(negedge clk);
    check("R8 second ext rx byte", rxData, 8'h01);
    check("R8 no overrun after read", overrun, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule